// File: doc/BRIEF.md
# Buck Channel Light-Load Mode Selector

This block is the digital mode selector for one channel of a synchronous buck controller. Once per oscillator period it decides whether the channel runs fixed-frequency PWM, where the high-side and low-side switches follow the PWM comparator, or a light-load hysteretic mode. In the hysteretic mode, high-side pulses start only at oscillator boundaries, and only while the sensed output sits below a lower threshold. The analog comparators, the error amplifier and the gate drivers are outside the block. They reach it as single-bit inputs.

Each oscillator period is marked by a one-clock strobe, `osc_tick`, on the system clock. At that strobe the switch-node polarity is sampled, which is the last moment of low-side conduction before the high side would turn on. A saturating streak counter tracks how many samples in a row point toward the other mode. Eight such samples change the mode. A sag comparator gives a fast way back to PWM. Soft-start, the forced-PWM input and, on a tracking channel, the DDR tracking mode each pin the channel in PWM. For the whole oscillator period that follows any mode change, both gate requests are held off.

Top module: `buck_mode_sel`

## Requirements
- R1: After reset the channel is in PWM mode (`mode_hyst`=0), the streak count is zero and `mode_chg`=0.
- R2: In PWM mode the channel enters hysteretic mode after 8 consecutive `osc_tick` samples with `sw_pos`=1. `mode_hyst` rises one clock after the eighth such strobe and not after the seventh.
- R3: A strobe that samples the opposite polarity (`sw_pos`=0 in PWM mode) restarts the streak, so a further 8 matching samples are needed.
- R4: In hysteretic mode the channel returns to PWM after 8 consecutive strobes with `sw_pos`=0.
- R5: In hysteretic mode, `out_below_sag`=1 at a strobe returns the channel to PWM one clock after that strobe, whatever the streak count.
- R6: In hysteretic mode, a strobe that sees `out_below_lo`=1 starts a high-side pulse, and `hs_on` goes high one clock later. Between pulses `pwm_req` has no effect on `hs_on`.
- R7: A hysteretic pulse ends one clock after `out_above_hi`=1 is seen on any clock, whether or not that clock carries a strobe.
- R8: Every mode change raises `mode_chg` for the oscillator period that follows it, until the next strobe. While `mode_chg` is high, `hs_on`=0 and `ls_on`=0.
- R9: When `ss_done`=0, or `auto_mode_en`=0, or `ddr_track_en`=1 on a channel built with `TRACK_CH`=1, a strobe forces PWM mode and clears the streak count.
- R10: In hysteretic mode with no pulse active, `ls_on` is 1 and drops to 0 whenever `ls_reverse`=1.
- R11: In PWM mode outside a mode change, `hs_on`=`pwm_req` and `ls_on`=!`pwm_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-clock strobe at each oscillator period boundary |
| sw_pos | input | 1 | Switch-node polarity at end of low-side conduction, 1 = positive |
| out_below_sag | input | 1 | Sensed output more than 20 mV below reference |
| out_below_lo | input | 1 | Sensed output more than 10 mV below reference |
| out_above_hi | input | 1 | Sensed output more than 5 mV above reference |
| auto_mode_en | input | 1 | 0 pins the channel in PWM mode |
| ddr_track_en | input | 1 | Tracking mode active, pins PWM when `TRACK_CH`=1 |
| ss_done | input | 1 | Soft-start complete |
| pwm_req | input | 1 | PWM comparator high-side request |
| ls_reverse | input | 1 | Low-side drain-source voltage shows reverse current |
| mode_hyst | output | 1 | 1 = hysteretic mode, 0 = PWM mode |
| hs_on | output | 1 | High-side switch request |
| ls_on | output | 1 | Low-side switch request |
| mode_chg | output | 1 | Both-off interval after a mode change |

## Verification
The mode, the transition flag and the pulse flag are registered. Each one changes on the clock edge that carries the deciding strobe, or on the edge that sees `out_above_hi`, so it is observable exactly one clock after the stimulus. `hs_on` and `ls_on` are combinational in those registers and in the live `pwm_req` and `ls_reverse`, so those two inputs act within the same clock. The bench changes inputs on the falling edge, holds `osc_tick` for one full clock, and reads outputs at the next falling edge, half a clock after the edge that acted on the stimulus. The streak boundaries (seventh versus eighth sample, a broken streak, a streak cleared by forcing) are checked at the first cycle where they become visible.

// File: rtl/mode_sel_pkg.sv
package mode_sel_pkg;

  typedef enum logic {
    MODE_PWM  = 1'b0,
    MODE_HYST = 1'b1
  } chan_mode_e;

endpackage

// File: rtl/polarity_streak.sv
module polarity_streak #(
  parameter int CNT_W  = 4,
  parameter int STREAK = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic match,
  output logic hit
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(STREAK - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    hit   = tick & match & ~clr & (cnt_q == LAST);
    cnt_d = cnt_q;
    if (tick) begin
      if (clr || hit || !match) begin
        cnt_d = '0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_d;
    end
  end

  // R3: a mismatching sample leaves the streak at zero
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !match) |=> (cnt_q == '0));

  // R9: forcing clears the streak
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr) |=> (cnt_q == '0));

  // R2: count only moves on a strobe
  a_r2_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

endmodule

// File: rtl/pfm_window.sv
module pfm_window (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  input  logic below_lo,
  input  logic above_hi,
  output logic pulse
);

  logic pulse_q;
  logic pulse_d;

  always_comb begin
    pulse_d = pulse_q;
    if (!active || above_hi) begin
      pulse_d = 1'b0;
    end else if (tick && below_lo) begin
      pulse_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  // R7: upper threshold ends the pulse on the next clock
  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    above_hi |=> !pulse_q);

  // R6: a pulse only begins on a strobe
  a_r6_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !pulse_q) |=> !pulse_q);

endmodule

// File: rtl/gate_steer.sv
module gate_steer
  import mode_sel_pkg::*;
(
  input  chan_mode_e mode,
  input  logic       chg,
  input  logic       pwm_req,
  input  logic       pulse,
  input  logic       ls_reverse,
  output logic       hs_on,
  output logic       ls_on
);

  always_comb begin
    hs_on = 1'b0;
    ls_on = 1'b0;
    if (!chg) begin
      if (mode == MODE_PWM) begin
        hs_on = pwm_req;
        ls_on = ~pwm_req;
      end else begin
        hs_on = pulse;
        ls_on = ~pulse & ~ls_reverse;
      end
    end
  end

endmodule

// File: rtl/buck_mode_sel.sv
module buck_mode_sel
  import mode_sel_pkg::*;
#(
  parameter int       CNT_W    = 4,
  parameter int       STREAK   = 8,
  parameter bit       TRACK_CH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic sw_pos,
  input  logic out_below_sag,
  input  logic out_below_lo,
  input  logic out_above_hi,
  input  logic auto_mode_en,
  input  logic ddr_track_en,
  input  logic ss_done,
  input  logic pwm_req,
  input  logic ls_reverse,
  output logic mode_hyst,
  output logic hs_on,
  output logic ls_on,
  output logic mode_chg
);

  // reset: asserted at once, released on a clock edge
  logic rst_meta_q;
  logic rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  chan_mode_e mode_q;
  chan_mode_e mode_d;
  logic       chg_q;
  logic       chg_d;
  logic       force_pwm;
  logic       sag_exit;
  logic       streak_match;
  logic       streak_hit;
  logic       pulse_active;
  logic       pulse;

  always_comb begin
    force_pwm    = ~ss_done | ~auto_mode_en | (TRACK_CH & ddr_track_en);
    sag_exit     = osc_tick & (mode_q == MODE_HYST) & out_below_sag;
    streak_match = (mode_q == MODE_PWM) ? sw_pos : ~sw_pos;
  end

  polarity_streak #(
    .CNT_W  (CNT_W),
    .STREAK (STREAK)
  ) u_streak (
    .clk   (clk),
    .rst_n (rst_s_n),
    .tick  (osc_tick),
    .clr   (force_pwm | sag_exit),
    .match (streak_match),
    .hit   (streak_hit)
  );

  always_comb begin
    mode_d = mode_q;
    chg_d  = chg_q;
    if (osc_tick) begin
      if (force_pwm || sag_exit) begin
        mode_d = MODE_PWM;
      end else if (streak_hit) begin
        mode_d = (mode_q == MODE_PWM) ? MODE_HYST : MODE_PWM;
      end
      chg_d = (mode_d != mode_q);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q <= MODE_PWM;
      chg_q  <= 1'b0;
    end else if (osc_tick) begin
      mode_q <= mode_d;
      chg_q  <= chg_d;
    end
  end

  assign pulse_active = (mode_q == MODE_HYST) && (mode_d == MODE_HYST);

  pfm_window u_pfm (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .tick     (osc_tick),
    .active   (pulse_active),
    .below_lo (out_below_lo),
    .above_hi (out_above_hi),
    .pulse    (pulse)
  );

  gate_steer u_steer (
    .mode       (mode_q),
    .chg        (chg_q),
    .pwm_req    (pwm_req),
    .pulse      (pulse),
    .ls_reverse (ls_reverse),
    .hs_on      (hs_on),
    .ls_on      (ls_on)
  );

  assign mode_hyst = (mode_q == MODE_HYST);
  assign mode_chg  = chg_q;

  // R9: a forced strobe always leaves PWM mode
  a_r9_forced_pwm: assert property (@(posedge clk) disable iff (!rst_s_n)
    (osc_tick && force_pwm) |=> (mode_q == MODE_PWM));

  // R5: sag at a strobe in hysteretic mode exits to PWM
  a_r5_sag_exit: assert property (@(posedge clk) disable iff (!rst_s_n)
    (osc_tick && mode_q == MODE_HYST && out_below_sag) |=> (mode_q == MODE_PWM));

  // R8: every mode change opens a both-off interval
  a_r8_chg_flag: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(mode_q) |-> chg_q);

  // R8: no gate request during the interval, never both at once
  a_r8_both_off: assert property (@(posedge clk) disable iff (!rst_s_n)
    chg_q |-> (!hs_on && !ls_on));

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(hs_on && ls_on));

  // R2: mode moves only on a strobe
  a_r2_mode_on_tick: assert property (@(posedge clk) disable iff (!rst_s_n)
    !osc_tick |=> $stable(mode_q));

endmodule

// File: tb/sim_buck_mode_sel.sv
module sim_buck_mode_sel;

  logic clk = 1'b0;
  logic rst_n;
  logic osc_tick, sw_pos, out_below_sag, out_below_lo, out_above_hi;
  logic auto_mode_en, ddr_track_en, ss_done, pwm_req, ls_reverse;
  logic mode_hyst, hs_on, ls_on, mode_chg;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  buck_mode_sel u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sw_pos(sw_pos),
    .out_below_sag(out_below_sag), .out_below_lo(out_below_lo),
    .out_above_hi(out_above_hi), .auto_mode_en(auto_mode_en),
    .ddr_track_en(ddr_track_en), .ss_done(ss_done), .pwm_req(pwm_req),
    .ls_reverse(ls_reverse), .mode_hyst(mode_hyst), .hs_on(hs_on),
    .ls_on(ls_on), .mode_chg(mode_chg)
  );

  task automatic check(input string req, input string what,
                       input logic actual, input logic expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, actual, expected);
    end
  endtask

  // one strobe: raised at a falling edge, dropped at the next; outputs read then
  task automatic tick(input logic pos);
    @(negedge clk);
    sw_pos   = pos;
    osc_tick = 1'b1;
    @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic ticks(input int n, input logic pos);
    for (int i = 0; i < n; i++) tick(pos);
  endtask

  task automatic enter_hyst();
    ticks(8, 1'b1);
    tick(1'b1);
  endtask

  task automatic t_reset();
    check("R1", "mode after reset", mode_hyst, 1'b0);
    check("R1", "chg after reset", mode_chg, 1'b0);
    check("R1", "ls_on after reset", ls_on, 1'b1);
  endtask

  task automatic t_pwm_follow();
    pwm_req = 1'b1; #1;
    check("R11", "hs follows pwm_req", hs_on, 1'b1);
    check("R11", "ls opposite pwm_req", ls_on, 1'b0);
    pwm_req = 1'b0; #1;
    check("R11", "hs low", hs_on, 1'b0);
  endtask

  task automatic t_streak_restart();
    ticks(7, 1'b1);
    tick(1'b0);
    ticks(7, 1'b1);
    check("R3", "still PWM after broken streak", mode_hyst, 1'b0);
    tick(1'b1);
    check("R2", "hysteretic after eighth positive", mode_hyst, 1'b1);
    check("R8", "chg raised", mode_chg, 1'b1);
    check("R8", "hs off in transition", hs_on, 1'b0);
    check("R8", "ls off in transition", ls_on, 1'b0);
  endtask

  task automatic t_pulse();
    out_below_lo = 1'b1;
    tick(1'b1);
    check("R8", "chg cleared next period", mode_chg, 1'b0);
    check("R6", "pulse started", hs_on, 1'b1);
    @(negedge clk);
    out_below_lo = 1'b0;
    out_above_hi = 1'b1;
    @(negedge clk);
    out_above_hi = 1'b0;
    check("R7", "pulse ended", hs_on, 1'b0);
    check("R10", "ls on between pulses", ls_on, 1'b1);
    pwm_req = 1'b1; ls_reverse = 1'b1; #1;
    check("R6", "pwm_req ignored in hysteretic", hs_on, 1'b0);
    check("R10", "ls off on reverse", ls_on, 1'b0);
    pwm_req = 1'b0; ls_reverse = 1'b0;
  endtask

  task automatic t_exit_streak();
    ticks(7, 1'b0);
    check("R4", "still hysteretic after 7 negatives", mode_hyst, 1'b1);
    tick(1'b0);
    check("R4", "PWM after 8 negatives", mode_hyst, 1'b0);
    check("R8", "chg on exit", mode_chg, 1'b1);
  endtask

  task automatic t_sag();
    enter_hyst();
    check("R2", "re-entered hysteretic", mode_hyst, 1'b1);
    out_below_sag = 1'b1;
    tick(1'b1);
    out_below_sag = 1'b0;
    check("R5", "sag exit to PWM", mode_hyst, 1'b0);
    check("R5", "sag exit chg", mode_chg, 1'b1);
  endtask

  task automatic t_force();
    enter_hyst();
    auto_mode_en = 1'b0;
    tick(1'b1);
    check("R9", "auto off forces PWM", mode_hyst, 1'b0);
    ticks(10, 1'b1);
    check("R9", "held PWM with auto off", mode_hyst, 1'b0);
    auto_mode_en = 1'b1;
    ss_done = 1'b0;
    ticks(10, 1'b1);
    check("R9", "held PWM in soft-start", mode_hyst, 1'b0);
    ss_done = 1'b1;
    ddr_track_en = 1'b1;
    ticks(10, 1'b1);
    check("R9", "held PWM in tracking mode", mode_hyst, 1'b0);
    ddr_track_en = 1'b0;
    ticks(4, 1'b1);
    auto_mode_en = 1'b0;
    tick(1'b1);
    auto_mode_en = 1'b1;
    ticks(4, 1'b1);
    check("R9", "streak cleared by forcing", mode_hyst, 1'b0);
    ticks(4, 1'b1);
    check("R9", "fresh streak of 8 enters", mode_hyst, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; osc_tick = 1'b0; sw_pos = 1'b0;
    out_below_sag = 1'b0; out_below_lo = 1'b0; out_above_hi = 1'b0;
    auto_mode_en = 1'b1; ddr_track_en = 1'b0; ss_done = 1'b1;
    pwm_req = 1'b0; ls_reverse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pwm_follow();
    t_streak_restart();
    t_pulse();
    t_exit_streak();
    t_sag();
    t_force();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule